// File: doc/BRIEF.md
# Fixed-Function Event Counter Unit

This block is a compact performance-monitoring unit holding four fixed-purpose event counters, each 48 bits wide. By convention, counter 0 tallies retired instructions, counter 1 unhalted core clocks, counter 2 unhalted reference clocks and counter 3 topdown slots. The event sources lie outside the block. Each counter takes one increment pulse per cycle from each of two logical threads that share a core, together with each thread's current privilege level. Thread 0 owns the configuration.

Two configuration registers sit on a simple single-cycle register bus.

- The per-counter control register holds, for each counter, a kernel-mode enable, a user-mode enable, a merge-both-threads option and an overflow-interrupt enable.
- The global enable register holds one enable per fixed counter, plus eight enables kept for general-purpose counters that live elsewhere.

A counter advances only when its global enable and its privilege enable both allow it. When it wraps, it sets a sticky status bit and can pulse an interrupt.

A separate indexed read port serves counter values to software. The value is returned as two 32-bit halves. Reads issued from user mode are refused unless a permission input is high.

Top module: `fxc_unit`

## Requirements
- R1: After reset, both configuration registers, the overflow status and all counters read zero; `irq` and `rd_valid` are low.
- R2: Counter n is configured by control bits 4n+3..4n. In that field, bit 0 lets events count while the thread is in kernel mode (`krn_tX`=1), and bit 1 lets them count while it is in user mode (`krn_tX`=0). An event whose mode bit is clear is not counted.
- R3: Global bits 32, 33 and 34 enable fixed counters 0, 1 and 2, and bit 48 enables fixed counter 3. A counter advances only when its global bit and its matching mode bit are both set.
- R4: Field bit 2 is the merge option. When it is clear, only thread 0 events count. When it is set, thread 1 events also count, gated by thread 1's own privilege level. Events from both threads in the same cycle add 2.
- R5: When a counter wraps past all-ones, status bit n at bus address 2 is set and stays set until a bus write to address 2 with bit n at 1 clears it. `irq` is high for the single cycle after the wrapping edge only if field bit 3 of a wrapping counter is set.
- R6: A read request returns `rd_valid` one cycle later with `rd_lo`/`rd_hi` holding bits 31:0 and 63:32 of the zero-extended counter. The fixed bank is selected by `rd_sel[30]`=1 with `rd_sel[31]`=0, and the index is `rd_sel[29:0]`. Any other selector, or an index of 4 or more, returns zero with no fault.
- R7: A read with `rd_user`=1 while `rd_perm`=0 returns `rd_fault`=1 and zero data. With `rd_perm`=1, or when `rd_user`=0, the read behaves as in R6.
- R8: Writes to reserved bits are dropped. Control bits 63:16 read back zero. The global register keeps only bits 7:0, 32, 33, 34 and 48.
- R9: The bus map is: 0 control, 1 global, 2 overflow status, 4+n counter n (read, and preset by writing). Writes take effect at the next clock edge, and a preset wins over a same-cycle increment. `bus_rdata` is combinational.
- R10: A control value of 0x333 with the four fixed global bits set makes counters 0–2 count in both modes, while counter 3 stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr` |
| evt_t0 | input | 4 | Per-counter event pulses from thread 0 |
| evt_t1 | input | 4 | Per-counter event pulses from thread 1 |
| krn_t0 | input | 1 | Thread 0 is in kernel mode |
| krn_t1 | input | 1 | Thread 1 is in kernel mode |
| rd_req | input | 1 | Counter read request |
| rd_sel | input | 32 | Read selector |
| rd_user | input | 1 | The read is issued from user mode |
| rd_perm | input | 1 | User-mode reads are permitted |
| rd_valid | output | 1 | Read result is valid |
| rd_lo | output | 32 | Low half of the result |
| rd_hi | output | 32 | High half of the result |
| rd_fault | output | 1 | The read was refused |
| irq | output | 1 | Overflow interrupt pulse |

## Verification
The assertions assume a bus write and an event to the same counter never conflict in a way that makes a preset look like a step. For that reason, the step-size checks are disabled in any cycle where a preset is present.

They also assume the event inputs are single pulses per counter and per thread. Under that assumption a counter can move by at most one per cycle with merging off and at most two with merging on.

The stimulus follows these assumptions as well:

- It changes events, privilege levels and bus signals only on the falling edge.
- It issues reads only while the event inputs are idle, so every value the scoreboard predicts is stable when sampled.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

  typedef struct packed {
    logic pmi;   // bit 3: interrupt on wrap
    logic any;   // bit 2: merge sibling thread
    logic usr;   // bit 1: count in user mode
    logic krn;   // bit 0: count in kernel mode
  } fx_field_t;

  // Global register position of fixed counter n
  function automatic int fx_glb_bit(int n);
    return (n < 3) ? (32 + n) : 48;
  endfunction

  function automatic logic [63:0] fx_ctrl_mask(int nf);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 4 * nf; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] fx_glb_mask(int np, int nf);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < np; i++) m[i] = 1'b1;
    for (int n = 0; n < nf; n++) m[fx_glb_bit(n)] = 1'b1;
    return m;
  endfunction

  // Increment for one counter this cycle: 0, 1 or 2
  function automatic logic [1:0] fx_step(fx_field_t f, logic en,
                                         logic e0, logic e1,
                                         logic k0, logic k1);
    logic a, b;
    a = e0 & (k0 ? f.krn : f.usr);
    b = f.any & e1 & (k1 ? f.krn : f.usr);
    return en ? ({1'b0, a} + {1'b0, b}) : 2'd0;
  endfunction

endpackage

// File: rtl/fxc_regs.sv
module fxc_regs
  import fxc_pkg::*;
#(
  parameter int NUM_FIXED = 4,
  parameter int NUM_PROG  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           addr,
  input  logic [63:0]          wdata,
  input  logic [NUM_FIXED-1:0] wrap_evt,
  output logic [63:0]          ctrl_q,
  output logic [63:0]          glb_q,
  output logic [NUM_FIXED-1:0] ovf_q
);
  localparam logic [63:0] CTRL_MASK = fx_ctrl_mask(NUM_FIXED);
  localparam logic [63:0] GLB_MASK  = fx_glb_mask(NUM_PROG, NUM_FIXED);

  logic                 st_clr;
  logic [NUM_FIXED-1:0] clr_bits;

  assign st_clr   = wr_en && (addr == 3'd2);
  assign clr_bits = st_clr ? wdata[NUM_FIXED-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      glb_q  <= '0;
      ovf_q  <= '0;
    end else begin
      if (wr_en && addr == 3'd0) ctrl_q <= wdata & CTRL_MASK;
      if (wr_en && addr == 3'd1) glb_q  <= wdata & GLB_MASK;
      ovf_q <= (ovf_q & ~clr_bits) | wrap_evt;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !st_clr |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R5

  AST_WRAP_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt != '0) |=> ((ovf_q & $past(wrap_evt)) == $past(wrap_evt))); // R5

endmodule

// File: rtl/fxc_counter.sv
module fxc_counter
  import fxc_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fx_field_t        field,
  input  logic             glb_en,
  input  logic             evt0,
  input  logic             evt1,
  input  logic             krn0,
  input  logic             krn1,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt,
  output logic             irq_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [1:0]     step;
  logic [CNT_W:0] sum;

  assign step     = fx_step(field, glb_en, evt0, evt1, krn0, krn1);
  assign sum      = {1'b0, cnt} + {{(CNT_W-1){1'b0}}, step};
  assign wrap_evt = sum[CNT_W] && !ld;
  assign irq_evt  = wrap_evt && field.pmi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (ld) cnt <= ld_val;
    else         cnt <= sum[CNT_W-1:0];
  end

  AST_GLB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !ld) |=> (cnt == $past(cnt))); // R3

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ((cnt - $past(cnt)) <= TWO)); // R4

  AST_SOLO_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !field.any) |=> ((cnt - $past(cnt)) <= ONE)); // R4

  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt <= ONE)); // R5

endmodule

// File: rtl/fxc_rdport.sv
module fxc_rdport #(
  parameter int NUM_FIXED = 4,
  parameter int CNT_W     = 48
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic [31:0]                sel,
  input  logic                       user,
  input  logic                       perm,
  input  logic [NUM_FIXED*CNT_W-1:0] cnt_flat,
  output logic                       valid,
  output logic [31:0]                lo,
  output logic [31:0]                hi,
  output logic                       fault
);
  localparam int IW = (NUM_FIXED > 1) ? $clog2(NUM_FIXED) : 1;

  logic          hit, deny;
  logic [IW-1:0] idx;
  logic [63:0]   val;

  assign deny = user && !perm;
  assign hit  = sel[30] && !sel[31] && (sel[29:0] < 30'(NUM_FIXED));
  assign idx  = sel[IW-1:0];

  always_comb begin
    val = '0;
    if (hit && !deny) val[CNT_W-1:0] = cnt_flat[idx*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      lo    <= '0;
      hi    <= '0;
      fault <= 1'b0;
    end else begin
      valid <= req;
      lo    <= req ? val[31:0]  : '0;
      hi    <= req ? val[63:32] : '0;
      fault <= req && deny;
    end
  end

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (valid && lo == '0 && hi == '0)); // R7

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> valid); // R6

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !valid); // R6

endmodule

// File: rtl/fxc_unit.sv
module fxc_unit
  import fxc_pkg::*;
#(
  parameter int NUM_FIXED = 4,
  parameter int NUM_PROG  = 8,
  parameter int CNT_W     = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [2:0]           bus_addr,
  input  logic [63:0]          bus_wdata,
  output logic [63:0]          bus_rdata,
  input  logic [NUM_FIXED-1:0] evt_t0,
  input  logic [NUM_FIXED-1:0] evt_t1,
  input  logic                 krn_t0,
  input  logic                 krn_t1,
  input  logic                 rd_req,
  input  logic [31:0]          rd_sel,
  input  logic                 rd_user,
  input  logic                 rd_perm,
  output logic                 rd_valid,
  output logic [31:0]          rd_lo,
  output logic [31:0]          rd_hi,
  output logic                 rd_fault,
  output logic                 irq
);
  logic [63:0]                ctrl_q, glb_q;
  logic [NUM_FIXED-1:0]       ovf_q, wrap_evt, irq_evt, ld;
  logic [CNT_W-1:0]           cnt_arr [NUM_FIXED];
  logic [NUM_FIXED*CNT_W-1:0] cnt_flat;

  fxc_regs #(.NUM_FIXED(NUM_FIXED), .NUM_PROG(NUM_PROG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .wrap_evt(wrap_evt),
    .ctrl_q(ctrl_q), .glb_q(glb_q), .ovf_q(ovf_q)
  );

  for (genvar n = 0; n < NUM_FIXED; n++) begin : g_cnt
    fx_field_t fld;
    assign fld      = fx_field_t'(ctrl_q[4*n +: 4]);
    assign ld[n]    = bus_we && bus_addr[2] && (bus_addr[1:0] == 2'(n));
    assign cnt_flat[n*CNT_W +: CNT_W] = cnt_arr[n];

    fxc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .field(fld),
      .glb_en(glb_q[fx_glb_bit(n)]),
      .evt0(evt_t0[n]), .evt1(evt_t1[n]),
      .krn0(krn_t0), .krn1(krn_t1),
      .ld(ld[n]), .ld_val(bus_wdata[CNT_W-1:0]),
      .cnt(cnt_arr[n]), .wrap_evt(wrap_evt[n]), .irq_evt(irq_evt[n])
    );
  end

  fxc_rdport #(.NUM_FIXED(NUM_FIXED), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .sel(rd_sel),
    .user(rd_user), .perm(rd_perm), .cnt_flat(cnt_flat),
    .valid(rd_valid), .lo(rd_lo), .hi(rd_hi), .fault(rd_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |irq_evt;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0: bus_rdata = ctrl_q;
      3'd1: bus_rdata = glb_q;
      3'd2: bus_rdata[NUM_FIXED-1:0] = ovf_q;
      3'd4, 3'd5, 3'd6, 3'd7:
        if (int'(bus_addr[1:0]) < NUM_FIXED)
          bus_rdata[CNT_W-1:0] = cnt_arr[bus_addr[1:0]];
      default: bus_rdata = '0;
    endcase
  end

  AST_IRQ_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_q != '0)); // R5

endmodule

// File: tb/test_fxc_unit.sv
module test_fxc_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [3:0]  evt_t0 = '0, evt_t1 = '0;
  logic        krn_t0 = 1'b1, krn_t1 = 1'b1;
  logic        rd_req = 1'b0;
  logic [31:0] rd_sel = '0;
  logic        rd_user = 1'b0, rd_perm = 1'b0;
  logic        rd_valid, rd_fault, irq;
  logic [31:0] rd_lo, rd_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] lo;
    logic [31:0] hi;
    logic        fault;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fxc_unit i_fxc_unit (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_t0(evt_t0), .evt_t1(evt_t1), .krn_t0(krn_t0), .krn_t1(krn_t1),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_user(rd_user), .rd_perm(rd_perm),
    .rd_valid(rd_valid), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_fault(rd_fault),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_is(input logic [2:0] a, input logic [63:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [3:0] e0, input logic [3:0] e1,
                       input logic k0, input logic k1, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_t0 = e0; evt_t1 = e1; krn_t0 = k0; krn_t1 = k1;
    end
    @(negedge clk);
    evt_t0 = '0; evt_t1 = '0;
  endtask

  // Driver: issue a read and push the value the requirements predict
  task automatic cnt_read(input logic [31:0] sel, input logic user, input logic perm,
                          input logic [63:0] exp_val, input logic exp_fault,
                          input string req);
    exp_t e;
    @(negedge clk);
    rd_req = 1'b1; rd_sel = sel; rd_user = user; rd_perm = perm;
    e.lo = exp_val[31:0]; e.hi = exp_val[63:32]; e.fault = exp_fault; e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // Monitor: pop and compare each returned result
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R6 unexpected rd_valid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({rd_fault, rd_hi, rd_lo} === {e.fault, e.hi, e.lo}, e.req,
            {31'd0, rd_fault, rd_hi, rd_lo}, {31'd0, e.fault, e.hi, e.lo});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [63:0] GLB_FX = 64'h0001_0007_0000_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_is(3'd0, 64'd0, "R1 ctrl");
    reg_is(3'd1, 64'd0, "R1 global");
    reg_is(3'd2, 64'd0, "R1 status");
    for (int n = 0; n < 4; n++) reg_is(3'(4 + n), 64'd0, "R1 counter");
    chk(irq === 1'b0, "R1 irq", {63'd0, irq}, 64'd0);
    chk(rd_valid === 1'b0, "R1 rd_valid", {63'd0, rd_valid}, 64'd0);

    // R8 reserved bits dropped
    bus_write(3'd0, '1);
    reg_is(3'd0, 64'h0000_0000_0000_FFFF, "R8 ctrl mask");
    bus_write(3'd1, '1);
    reg_is(3'd1, 64'h0001_0007_0000_00FF, "R8 global mask");

    // R3 global off blocks counting
    bus_write(3'd0, 64'h333);
    bus_write(3'd1, 64'd0);
    pulse(4'hF, 4'h0, 1'b1, 1'b1, 5);
    reg_is(3'd4, 64'd0, "R3 global off");

    // R10 0x333 counts kernel and user on counters 0..2
    bus_write(3'd1, GLB_FX);
    pulse(4'hF, 4'h0, 1'b1, 1'b1, 5);
    pulse(4'hF, 4'h0, 1'b0, 1'b0, 2);
    reg_is(3'd4, 64'd7, "R10 counter0");
    reg_is(3'd5, 64'd7, "R10 counter1");
    reg_is(3'd6, 64'd7, "R10 counter2");
    reg_is(3'd7, 64'd0, "R10 counter3 disabled field");

    // R2 per-mode enables
    bus_write(3'd0, 64'h21);
    for (int n = 0; n < 4; n++) bus_write(3'(4 + n), 64'd0);
    pulse(4'hF, 4'h0, 1'b1, 1'b1, 3);
    pulse(4'hF, 4'h0, 1'b0, 1'b0, 4);
    reg_is(3'd4, 64'd3, "R2 kernel only");
    reg_is(3'd5, 64'd4, "R2 user only");
    reg_is(3'd6, 64'd0, "R2 field clear");

    // R4 merge option
    bus_write(3'd0, 64'h73);
    bus_write(3'd4, 64'd0);
    bus_write(3'd5, 64'd0);
    pulse(4'h3, 4'h3, 1'b1, 1'b1, 6);
    reg_is(3'd4, 64'd6, "R4 owner only");
    reg_is(3'd5, 64'd12, "R4 both threads add");
    pulse(4'h0, 4'h3, 1'b1, 1'b0, 2);
    reg_is(3'd4, 64'd6, "R4 sibling ignored");
    reg_is(3'd5, 64'd14, "R4 sibling user mode");

    // R9 preset wins over increment
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 64'd100; evt_t0 = 4'h2;
    @(negedge clk);
    bus_we = 1'b0; evt_t0 = '0;
    reg_is(3'd5, 64'd100, "R9 preset wins");

    // R5 wrap without interrupt enable
    bus_write(3'd0, 64'h3B);
    bus_write(3'd5, 64'h0000_FFFF_FFFF_FFFF);
    pulse(4'h2, 4'h0, 1'b1, 1'b1, 1);
    chk(irq === 1'b0, "R5 no irq without enable", {63'd0, irq}, 64'd0);
    reg_is(3'd2, 64'h2, "R5 status set");
    reg_is(3'd5, 64'd0, "R5 wrapped to zero");
    // R5 wrap with interrupt enable
    bus_write(3'd4, 64'h0000_FFFF_FFFF_FFFF);
    pulse(4'h1, 4'h0, 1'b1, 1'b1, 1);
    chk(irq === 1'b1, "R5 irq pulse", {63'd0, irq}, 64'd1);
    reg_is(3'd2, 64'h3, "R5 status sticky");
    @(negedge clk);
    chk(irq === 1'b0, "R5 irq single cycle", {63'd0, irq}, 64'd0);
    bus_write(3'd2, 64'h1);
    reg_is(3'd2, 64'h2, "R5 clear bit0");
    bus_write(3'd2, 64'h2);
    reg_is(3'd2, 64'h0, "R5 clear bit1");

    // R6/R7 read port
    bus_write(3'd6, 64'h0000_1234_5678_9ABC);
    cnt_read(32'h4000_0002, 1'b0, 1'b0, 64'h0000_1234_5678_9ABC, 1'b0, "R6 kernel read");
    cnt_read(32'h4000_0005, 1'b0, 1'b0, 64'd0, 1'b0, "R6 index beyond bank");
    cnt_read(32'h0000_0002, 1'b0, 1'b0, 64'd0, 1'b0, "R6 bank bit clear");
    cnt_read(32'h4000_0002, 1'b1, 1'b0, 64'd0, 1'b1, "R7 user denied");
    cnt_read(32'h4000_0002, 1'b1, 1'b1, 64'h0000_1234_5678_9ABC, 1'b0, "R7 user permitted");
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R6 all reads returned", 64'(sb_q.size()), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule